// File: doc/BRIEF.md
# Multicycle Accumulator Sequencer

This block is the control and datapath core of a 16-bit single-accumulator processor that addresses 4096 words. It holds the program counter, the address, instruction and data registers, the accumulator with its carry link bit, and a small step counter. Each instruction runs as a fixed series of steps. The controller clears the counter when the instruction is done, and the next instruction is then fetched from the program counter.

Instruction words use three fields. Bit 15 marks an indirect operand. Bits 14..12 hold the operation code. Bits 11..0 hold the operand address. The core carries out the seven memory-operand operations itself. Operation code 7 (binary 111) is passed to a neighbouring unit over a valid/ready handoff. Memory is synchronous: data for a read strobed in one cycle is present on `mem_rdata` during the next cycle and is held until the next read.

The handoff follows these back-pressure rules. `ext_valid` rises in step 3 of an operation-code-7 instruction. While `ext_ready` is low, `ext_valid`, `ext_io` and `ext_code` hold steady and no memory strobe is issued. The transfer completes on the first clock edge where both are high, and the next fetch starts in the following cycle.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is low, and on the first cycle after it, the program counter, accumulator and link read zero, and `mem_rd`, `mem_wr` and `ext_valid` are low.
- R2: Fetch reads the word at the program counter, one read per instruction, and the program counter then advances by one. Each instruction's effects appear in program order.
- R3: When bit 15 is set and the operation code is 0 to 6, one extra memory read at the address field supplies the effective address (its low 12 bits). When bit 15 is clear, the address field itself is the effective address.
- R4: Code 0 (AND) sets the accumulator to the accumulator AND the operand. Code 1 (ADD) sets it to the 16-bit sum and puts the carry-out in the link bit. Code 2 (LDA) loads the operand.
- R5: Code 3 (STA) writes the accumulator to the effective address. A cycle never asserts both `mem_rd` and `mem_wr`.
- R6: Code 4 (BUN) loads the program counter with the effective address.
- R7: Code 5 (BSA) writes the return address (the incremented program counter) to the effective address, zero-extended, and continues at the effective address plus one.
- R8: Code 6 (ISZ) writes the operand plus one back to the effective address. If that value is zero, the following instruction is skipped.
- R9: Code 7 raises `ext_valid` with `ext_io` equal to bit 15 and `ext_code` equal to bits 11..0. These outputs hold, with no memory strobes, until `ext_ready` is sampled high.
- R10: The step counter never exceeds 6. It returns to step 0 after a completed handoff or a finished instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe; data is on mem_rdata in the next cycle |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| ext_valid | output | 1 | Operation-code-7 instruction offered to the neighbour unit |
| ext_ready | input | 1 | Neighbour unit accepts the handoff |
| ext_io | output | 1 | Bit 15 of the handed-off instruction |
| ext_code | output | 12 | Bits 11..0 of the handed-off instruction |
| acc | output | 16 | Accumulator |
| link | output | 1 | Carry link bit |
| pc | output | 12 | Program counter |

## Verification
The properties assume that the memory returns read data exactly one cycle after a strobe and holds it, and that `ext_ready` only matters while `ext_valid` is high. The bench memory model answers every read in the following cycle. The bench changes `ext_ready` only one time unit after a rising edge, and raises it only while a handoff is pending, after holding it low for several cycles to apply back-pressure. The program covers direct and indirect operands, a carry out of ADD, and ISZ both with and without a skip, so the write stream and handoff stream fully show address selection and ordering.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  // decoded operation indices
  localparam int K_AND = 0;
  localparam int K_ADD = 1;
  localparam int K_LDA = 2;
  localparam int K_STA = 3;
  localparam int K_BUN = 4;
  localparam int K_BSA = 5;
  localparam int K_ISZ = 6;
  localparam int K_EXT = 7;
  localparam int LAST_STEP = 6;
endpackage

// File: rtl/acc_step_ctr.sv
module acc_step_ctr #(
  parameter int SC_W = 4,
  parameter int NT   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            clr,
  output logic [SC_W-1:0] sc,
  output logic [NT-1:0]   t
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sc <= '0;
    else if (clr) sc <= '0;
    else if (inc) sc <= sc + SC_W'(1);
  end

  for (genvar i = 0; i < NT; i++) begin : g_dec
    assign t[i] = (sc == SC_W'(i));
  end
endmodule

// File: rtl/acc_op_dec.sv
module acc_op_dec #(
  parameter int N = 3,
  localparam int M = 1 << N
) (
  input  logic [N-1:0] code,
  output logic [M-1:0] d
);
  for (genvar i = 0; i < M; i++) begin : g_dec
    assign d[i] = (code == N'(i));
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 16
) (
  input  logic          sel_and,
  input  logic          sel_add,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          cout
);
  logic [DW:0] sum;
  always_comb begin
    sum  = {1'b0, a} + {1'b0, b};
    cout = sum[DW];
    if (sel_and)      res = a & b;
    else if (sel_add) res = sum[DW-1:0];
    else              res = b;
  end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int SC_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          ext_valid,
  input  logic          ext_ready,
  output logic          ext_io,
  output logic [AW-1:0] ext_code,
  output logic [DW-1:0] acc,
  output logic          link,
  output logic [AW-1:0] pc
);
  localparam int OPW = DW - 1 - AW;
  localparam int ND  = 1 << OPW;
  localparam int NT  = LAST_STEP + 1;

  logic [AW-1:0]   pc_q, ar_q, ea;
  logic [DW-1:0]   ir_q, dr_q, ac_q, alu_res;
  logic            i_q, e_q, alu_c;
  logic [SC_W-1:0] sc_q;
  logic [NT-1:0]   t;
  logic [ND-1:0]   d;
  logic            memref, rd_opnd, sc_clr, sc_inc, stall;

  acc_step_ctr #(.SC_W(SC_W), .NT(NT)) u_sc (
    .clk(clk), .rst_n(rst_n), .inc(sc_inc), .clr(sc_clr), .sc(sc_q), .t(t)
  );

  acc_op_dec #(.N(OPW)) u_dec (.code(ir_q[DW-2 -: OPW]), .d(d));

  acc_alu #(.DW(DW)) u_alu (
    .sel_and(d[K_AND]), .sel_add(d[K_ADD]), .a(ac_q), .b(mem_rdata),
    .res(alu_res), .cout(alu_c)
  );

  // control decode
  always_comb begin
    memref  = !d[K_EXT];
    rd_opnd = d[K_AND] | d[K_ADD] | d[K_LDA] | d[K_ISZ];
    // effective address: pointer word arrives in step 4 when indirect
    ea      = i_q ? mem_rdata[AW-1:0] : ar_q;
    stall   = t[3] & d[K_EXT] & !ext_ready;
    sc_clr  = (t[3] & d[K_EXT] & ext_ready)
            | (t[4] & (d[K_STA] | d[K_BUN]))
            | (t[5] & (d[K_AND] | d[K_ADD] | d[K_LDA] | d[K_BSA]))
            | t[6];
    sc_inc  = !sc_clr && !stall;
    mem_rd  = t[1] | (t[3] & memref & i_q) | (t[4] & rd_opnd);
    mem_wr  = (t[4] & (d[K_STA] | d[K_BSA])) | (t[6] & d[K_ISZ]);
    mem_addr = t[4] ? ea : ar_q;
    if (d[K_STA])      mem_wdata = ac_q;
    else if (d[K_BSA]) mem_wdata = {{(DW-AW){1'b0}}, pc_q};
    else               mem_wdata = dr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0; ar_q <= '0; ir_q <= '0; dr_q <= '0;
      ac_q <= '0; i_q  <= 1'b0; e_q <= 1'b0;
    end else begin
      if (t[0]) ar_q <= pc_q;
      if (t[1]) pc_q <= pc_q + AW'(1);
      if (t[2]) begin
        ir_q <= mem_rdata;
        ar_q <= mem_rdata[AW-1:0];
        i_q  <= mem_rdata[DW-1];
      end
      if (t[4] && memref) ar_q <= d[K_BSA] ? ea + AW'(1) : ea;
      if (t[4] && d[K_BUN]) pc_q <= ea;
      if (t[5] && d[K_BSA]) pc_q <= ar_q;
      if (t[5] && (d[K_AND] || d[K_ADD] || d[K_LDA])) begin
        dr_q <= mem_rdata;
        ac_q <= alu_res;
        if (d[K_ADD]) e_q <= alu_c;
      end
      if (t[5] && d[K_ISZ]) dr_q <= mem_rdata + DW'(1);
      if (t[6] && d[K_ISZ] && dr_q == '0) pc_q <= pc_q + AW'(1);
    end
  end

  assign ext_valid = t[3] & d[K_EXT];
  assign ext_io    = i_q;
  assign ext_code  = ir_q[AW-1:0];
  assign acc       = ac_q;
  assign link      = e_q;
  assign pc        = pc_q;
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
  parameter int AW   = 12,
  parameter int SC_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SC_W-1:0] sc,
  input logic [AW-1:0]   pc,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            ext_valid,
  input logic            ext_ready,
  input logic [AW-1:0]   ext_code
);
  a_r5_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r10_sc_limit: assert property (@(posedge clk) disable iff (!rst_n)
    sc <= SC_W'(6));

  a_r10_sc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && ext_ready) |=> (sc == '0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_code)));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> (!mem_rd && !mem_wr));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == SC_W'(1)) |=> (pc == $past(pc) + AW'(1)));
endmodule

bind acc_seq_core acc_seq_chk #(.AW(AW), .SC_W(SC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sc(sc_q), .pc(pc), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .ext_valid(ext_valid), .ext_ready(ext_ready),
  .ext_code(ext_code)
);

// File: tb/sim_acc_seq_core.sv
module sim_acc_seq_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        ext_valid, ext_io;
  logic        ext_ready = 1'b0;
  logic [11:0] ext_code;
  logic [15:0] acc;
  logic        link;
  logic [11:0] pc;

  acc_seq_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_io(ext_io),
    .ext_code(ext_code), .acc(acc), .link(link), .pc(pc)
  );

  always #2 clk = ~clk;

  logic [15:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
  end

  typedef struct {
    bit          is_ext;
    logic [11:0] a;
    logic [15:0] v;
    string       req;
  } item_t;
  item_t exp_q[$];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input bit is_ext, input logic [11:0] a,
                      input logic [15:0] v, input string req);
    item_t it;
    it.is_ext = is_ext; it.a = a; it.v = v; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: compares writes and completed handoffs in order
  always @(negedge clk) begin
    if (rst_n && (mem_wr || (ext_valid && ext_ready))) begin
      item_t it;
      bit    is_ext;
      logic [11:0] a;
      logic [15:0] v;
      is_ext = !mem_wr;
      a = is_ext ? ext_code : mem_addr;
      v = is_ext ? {15'b0, ext_io} : mem_wdata;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected event", {3'b0, is_ext, a, v}, 32'h0);
      end else begin
        it = exp_q.pop_front();
        check(it.is_ext == is_ext && it.a == a && it.v == v, it.req,
              {3'b0, is_ext, a, v}, {3'b0, it.is_ext, it.a, it.v});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", pc, 12'h210);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    mem[12'h000] = 16'h2100;  // LDA 100
    mem[12'h001] = 16'h1101;  // ADD 101
    mem[12'h002] = 16'h8102;  // AND @102
    mem[12'h003] = 16'h3104;  // STA 104
    mem[12'h004] = 16'h6105;  // ISZ 105 -> skip
    mem[12'h005] = 16'h31FF;  // skipped
    mem[12'h006] = 16'h6106;  // ISZ 106 -> no skip
    mem[12'h007] = 16'hD107;  // BSA @107
    mem[12'h100] = 16'h1234;
    mem[12'h101] = 16'hF000;
    mem[12'h102] = 16'h0103;
    mem[12'h103] = 16'h00FF;
    mem[12'h105] = 16'hFFFF;
    mem[12'h106] = 16'h0005;
    mem[12'h107] = 16'h0200;
    mem[12'h108] = 16'h0300;
    mem[12'h201] = 16'h7800;  // handoff, register kind
    mem[12'h202] = 16'hF080;  // handoff, io kind
    mem[12'h203] = 16'hB108;  // STA @108
    mem[12'h204] = 16'h4210;  // BUN 210
    mem[12'h210] = 16'h4210;  // self loop

    push(1'b0, 12'h104, 16'h0034, "R4 R5 STA after LDA/ADD/AND@");
    push(1'b0, 12'h105, 16'h0000, "R8 ISZ wrap write");
    push(1'b0, 12'h106, 16'h0006, "R8 ISZ after skip");
    push(1'b0, 12'h200, 16'h0008, "R7 BSA return address");
    push(1'b1, 12'h800, 16'h0000, "R9 handoff register kind");
    push(1'b1, 12'h080, 16'h0001, "R9 handoff io kind");
    push(1'b0, 12'h300, 16'h0034, "R3 STA indirect");

    repeat (3) @(negedge clk);
    check(pc == 12'h0, "R1 pc reset", pc, 0);
    check(acc == 16'h0, "R1 acc reset", acc, 0);
    check(link == 1'b0, "R1 link reset", link, 0);
    check(!mem_rd && !mem_wr && !ext_valid, "R1 strobes idle",
          {mem_rd, mem_wr, ext_valid}, 0);
    @(posedge clk) #1 rst_n = 1'b1;

    for (int k = 0; k < 2; k++) begin
      logic [11:0] code0, pc0;
      do @(negedge clk); while (!ext_valid);
      code0 = ext_code;
      pc0   = pc;
      for (int w = 0; w < 3; w++) begin
        @(negedge clk);
        check(ext_valid && ext_code == code0 && !mem_rd && !mem_wr && pc == pc0,
              "R9 hold under back-pressure", {ext_valid, mem_rd, mem_wr, ext_code},
              {3'b100, code0});
      end
      @(posedge clk) #1 ext_ready = 1'b1;
      @(posedge clk) #1 ext_ready = 1'b0;
    end

    for (int c = 0; c < 200 && pc != 12'h210; c++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(pc == 12'h210, "R6 BUN target", pc, 12'h210);
    check(acc == 16'h0034, "R4 final accumulator", acc, 16'h0034);
    check(link == 1'b1, "R4 ADD carry into link", link, 1);
    check(exp_q.size() == 0, "R2 all events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule